// File: doc/BRIEF.md
# E3 Receive Loss-of-Signal Detector

This block watches the two rails of an E3 receive line (positive and negative) once per recovered bit clock. It also watches the loss-of-signal input from the external line receiver. It produces a registered loss-of-signal status and a one-cycle pulse whenever that status changes, which interrupt logic can use.

An internal detector counts consecutive bit periods in which both rails are low. A mode enable chooses how the status is formed:

- **Enable low:** the status follows the external receiver pin alone.
- **Enable high:** the status is the OR of the external pin and the internal zero-run condition.

The counter runs whatever the enable setting is, so a change of the enable takes effect on the next clock. A soft-reset command returns all state to its defaults, as the system reset does.

Top module: `e3_rx_los_detect`

## Requirements
- R1: With `zero_los_en`=1 and `ext_los`=0, `los_status` rises at the clock edge that samples the 32nd consecutive bit period with `rx_pos`=0 and `rx_neg`=0. The run counter saturates, so `los_status` stays 1 for any longer run.
- R2: A run of 31 consecutive all-zero bit periods does not set `los_status`.
- R3: At the edge that samples a 1 on `rx_pos` or on `rx_neg`, the internal condition clears. With `ext_los`=0, `los_status` is 0 after that edge, and a new run of 32 zeros is needed to set it again.
- R4: With `zero_los_en`=0, zero runs of any length on the rails have no effect, and `los_status` equals `ext_los` as sampled at the previous edge.
- R5: With `zero_los_en`=1, `los_status` after an edge equals the sampled `ext_los` ORed with the internal zero-run condition.
- R6: `ext_los`=1 sets `los_status` at the next edge for either value of `zero_los_en`.
- R7: `los_event` is 1 for exactly the one cycle in which `los_status` takes a new value, and 0 otherwise.
- R8: `rst` or `soft_rst` clears `los_status`, `los_event` and the zero-run count at the edge where either is high. Holding `soft_rst` at 0 has no effect.
- R9: The zero-run counter keeps counting while `zero_los_en`=0. Raising the enable after 32 or more zeros sets `los_status` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Register-commanded reset, active high, synchronous |
| rx_pos | input | 1 | Positive-rail receive data |
| rx_neg | input | 1 | Negative-rail receive data |
| ext_los | input | 1 | Loss-of-signal indication from the external line receiver |
| zero_los_en | input | 1 | 1: OR the internal zero-run detector with `ext_los`; 0: use `ext_los` only |
| los_status | output | 1 | Registered loss-of-signal status |
| los_event | output | 1 | One-cycle pulse on each change of `los_status` |

## Verification
The bench builds the block with the default run length of 32. This puts the 31-zero, 32-zero and 33-zero boundaries, and a long saturated run, within a few dozen cycles. Directed tasks cover the following:

- clearing the condition with a single 1 on each rail;
- all four pairings of `ext_los` with the enable, both with and without a saturated zero run;
- raising the enable on a run that built up while it was low;
- a soft reset in the middle of a loss condition, after which exactly 32 fresh zeros are needed again.

// File: rtl/e3los_pkg.sv
package e3los_pkg;
  // Consecutive all-zero bit periods that declare internal loss of signal
  localparam int unsigned DEF_RUN_LEN = 32;

  function automatic int unsigned run_cnt_width(input int unsigned run_len);
    return $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int unsigned RUN_LEN = e3los_pkg::DEF_RUN_LEN,
  parameter int unsigned CNT_W   = e3los_pkg::run_cnt_width(RUN_LEN)
) (
  input  logic clk,
  input  logic clr,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic run_hit   // this sample completes (or extends) a full run
);
  localparam logic [CNT_W-1:0] LIMIT      = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] LIMIT_LESS = CNT_W'(RUN_LEN - 1);

  logic             both_low;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign both_low = ~rx_pos & ~rx_neg;

  always_comb begin
    if (!both_low)          cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = LIMIT;
    else                    cnt_d = cnt_q + 1'b1;
  end

  assign run_hit = both_low && (cnt_q >= LIMIT_LESS);

  always_ff @(posedge clk) begin
    if (clr) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // Count never passes the saturation point (R1)
  p_cnt_saturates_r1: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= LIMIT);

  // A one on either rail empties the counter (R3)
  p_one_clears_r3: assert property (@(posedge clk) disable iff (clr)
    (rx_pos || rx_neg) |=> (cnt_q == '0));
endmodule

// File: rtl/los_source_select.sv
module los_source_select (
  input  logic clk,
  input  logic clr,
  input  logic run_hit,
  input  logic ext_los,
  input  logic zero_los_en,
  output logic los_next,
  output logic los_q
);
  assign los_next = ext_los | (zero_los_en & run_hit);

  always_ff @(posedge clk) begin
    if (clr) los_q <= 1'b0;
    else     los_q <= los_next;
  end

  // External pin forces loss on the next edge (R6)
  p_ext_forces_r6: assert property (@(posedge clk) disable iff (clr)
    ext_los |=> los_q);

  // With the detector disabled, only the pin matters (R4)
  p_rails_ignored_r4: assert property (@(posedge clk) disable iff (clr)
    (!zero_los_en && !ext_los) |=> !los_q);
endmodule

// File: rtl/los_event_gen.sv
module los_event_gen (
  input  logic clk,
  input  logic clr,
  input  logic los_next,
  input  logic los_q,
  output logic evt_q
);
  always_ff @(posedge clk) begin
    if (clr) evt_q <= 1'b0;
    else     evt_q <= los_next ^ los_q;
  end
endmodule

// File: rtl/e3_rx_los_detect.sv
module e3_rx_los_detect #(
  parameter int unsigned RUN_LEN = e3los_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic ext_los,
  input  logic zero_los_en,
  output logic los_status,
  output logic los_event
);
  localparam int unsigned CNT_W = e3los_pkg::run_cnt_width(RUN_LEN);

  logic clr;
  logic run_hit;
  logic los_next;

  assign clr = rst | soft_rst;

  zero_run_counter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_run (
    .clk(clk), .clr(clr), .rx_pos(rx_pos), .rx_neg(rx_neg), .run_hit(run_hit)
  );

  los_source_select u_sel (
    .clk(clk), .clr(clr), .run_hit(run_hit), .ext_los(ext_los),
    .zero_los_en(zero_los_en), .los_next(los_next), .los_q(los_status)
  );

  los_event_gen u_evt (
    .clk(clk), .clr(clr), .los_next(los_next), .los_q(los_status),
    .evt_q(los_event)
  );

  // Event pulses exactly when the status output changes (R7)
  p_event_on_change_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(soft_rst) && !$past(rst) |-> (los_event == (los_status != $past(los_status))));

  // Soft reset returns outputs to defaults (R8)
  p_soft_clear_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!los_status && !los_event));
endmodule

// File: tb/e3_rx_los_detect_tb.sv
`timescale 1ns/1ps
module e3_rx_los_detect_tb_top;
  logic clk = 1'b0;
  logic rst, soft_rst, rx_pos, rx_neg, ext_los, zero_los_en;
  logic los_status, los_event;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  e3_rx_los_detect dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .ext_los(ext_los), .zero_los_en(zero_los_en),
    .los_status(los_status), .los_event(los_event)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bit period, let it be sampled, settle
  task automatic bit_in(input logic p, input logic n);
    @(negedge clk);
    rx_pos = p; rx_neg = n;
    @(posedge clk);
    #1;
  endtask

  task automatic zeros(input int cnt);
    for (int i = 0; i < cnt; i++) bit_in(1'b0, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1; soft_rst = 0; rx_pos = 0; rx_neg = 0; ext_los = 0; zero_los_en = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 reset status", los_status, 1'b0);
    chk("R8 reset event", los_event, 1'b0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_run_boundaries;
    zero_los_en = 1; ext_los = 0;
    bit_in(1'b1, 1'b0);
    zeros(31);
    chk("R2 31 zeros", los_status, 1'b0);
    chk("R7 no event at 31", los_event, 1'b0);
    zeros(1);
    chk("R1 32 zeros", los_status, 1'b1);
    chk("R7 event on rise", los_event, 1'b1);
    zeros(1);
    chk("R1 33 zeros", los_status, 1'b1);
    chk("R7 single-cycle event", los_event, 1'b0);
    zeros(60);
    chk("R1 saturated long run", los_status, 1'b1);
  endtask

  task automatic t_rail_ones;
    bit_in(1'b1, 1'b0);
    chk("R3 pos rail clears", los_status, 1'b0);
    chk("R7 event on fall", los_event, 1'b1);
    zeros(31);
    chk("R3 restart needs full run", los_status, 1'b0);
    zeros(1);
    chk("R3 run rebuilt", los_status, 1'b1);
    bit_in(1'b0, 1'b1);
    chk("R3 neg rail clears", los_status, 1'b0);
  endtask

  task automatic t_disabled;
    zero_los_en = 0; ext_los = 0;
    zeros(40);
    chk("R4 zeros ignored when disabled", los_status, 1'b0);
    chk("R4 no event when disabled", los_event, 1'b0);
    @(negedge clk); zero_los_en = 1; rx_pos = 0; rx_neg = 0;
    @(posedge clk); #1;
    chk("R9 counter ran while disabled", los_status, 1'b1);
    @(negedge clk); zero_los_en = 0;
    @(posedge clk); #1;
    chk("R4 disable drops status", los_status, 1'b0);
  endtask

  task automatic t_combos;
    for (int e = 0; e < 2; e++) begin
      for (int x = 0; x < 2; x++) begin
        // no internal run: rails active
        @(negedge clk); zero_los_en = e[0]; ext_los = x[0]; rx_pos = 1; rx_neg = 0;
        @(posedge clk); #1;
        chk(e ? "R5 pin only, enabled" : "R6 pin only, disabled", los_status, x[0]);
        zeros(32);
        chk(e ? "R5 run OR pin" : "R4 run ignored, pin kept", los_status, x[0] | e[0]);
      end
    end
    @(negedge clk); ext_los = 0;
  endtask

  task automatic t_soft_reset;
    zero_los_en = 1; ext_los = 0;
    bit_in(1'b1, 1'b1);
    zeros(32);
    chk("R1 before soft reset", los_status, 1'b1);
    @(negedge clk); soft_rst = 1; rx_pos = 0; rx_neg = 0;
    @(posedge clk); #1;
    chk("R8 soft reset status", los_status, 1'b0);
    chk("R8 soft reset event", los_event, 1'b0);
    @(negedge clk); soft_rst = 0;
    @(posedge clk); #1;   // first zero after reset
    zeros(30);
    chk("R8 count cleared by soft reset", los_status, 1'b0);
    zeros(1);
    chk("R8 full run after soft reset", los_status, 1'b1);
    zeros(3);
    chk("R8 soft_rst low has no effect", los_status, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_run_boundaries();
    t_rail_ones();
    t_disabled();
    t_combos();
    t_soft_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule